// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits at the end of a 16-bit sampling converter's data path, directly ahead of the serializer. Each valid sample produces exactly one output word. When the 4-bit test select is zero, that word is the live converter sample. When the select is nonzero, the block puts a synthetic word in its place. The synthetic words are fixed levels, alternating or cycling words, two pseudo-random streams of different lengths, a one-time sync marker, and two user-supplied words. The user words can be played repeatedly or only once.

Patterns are built in offset-binary form. The last two steps, in this order, are an optional conversion to two's complement (flip of the MSB) and an optional complement of every bit. The output is registered. It changes only on a clock edge where the sample strobe is high, and it holds between samples.

A small sequence engine tracks the position inside an alternating or once-only pattern. It has three states. SEQ_FIRST emits the first word of a pair. SEQ_SECOND emits the second word. SEQ_HOLD is where a once-only pattern parks, and it then emits midscale. The transitions are:
- SEQ_FIRST→SEQ_SECOND on a sample in a repeating pattern.
- SEQ_FIRST→SEQ_HOLD on a sample in sync mode or single-once user mode.
- SEQ_SECOND→SEQ_FIRST on a sample in a repeating pattern.
- SEQ_SECOND→SEQ_HOLD on a sample in alternate-once user mode.
- SEQ_HOLD→SEQ_HOLD on every sample.
- Any state→SEQ_FIRST when the selected mode changes.

Top module: `tpg_top`

## Requirements
- R1: With test select 0000, or any reserved value 1101 to 1111, the output is the input sample. The output register loads only on a clock edge where `smp_vld` is high, so the new word is visible after that edge, and it holds its value while `smp_vld` is low.
- R2: Fixed levels in offset-binary form are 0x8000 for select 0001 (midscale), 0xFFFF for select 0010 (positive full scale) and 0x0000 for select 0011 (negative full scale).
- R3: Each of the following pairs alternates on successive samples, and the first sample after the mode is entered carries the first word. Select 0100 alternates 0xAAAA and 0x5555. Select 0111 alternates 0x0000 and 0xFFFF. Select 1001 alternates 0x3333 and 0xCCCC. Cycles with `smp_vld` low do not advance the alternation.
- R4: Select 1100 cycles through 0xA0A0, 0x5F5F, 0xF5F5 and 0x0A0A. Select 1011 emits a single set bit that starts at bit 0, moves up one position per sample, and wraps from bit 15 back to bit 0.
- R5: Select 1010 emits 0xFF00 on the first sample after the mode is entered and emits midscale (0x8000) on every sample after that.
- R6: Select 0101 outputs the low 16 bits of a 23-bit shift register. The register has feedback bit[22] XOR bit[17] shifted into bit 0, is seeded to all ones, and steps once per valid sample in every mode.
- R7: Select 0110 outputs a 16-bit shift register. The register has feedback bit[8] XOR bit[4] shifted into bit 0, is seeded to all ones, and steps once per valid sample in every mode.
- R8: `pn_long_rst` reseeds only the 23-bit generator and `pn_short_rst` reseeds only the 16-bit one. A sample taken in the same cycle as the reseed already shows the seed word 0xFFFF.
- R9: With select 1000, user mode 00 emits word A on every sample, and user mode 01 alternates word A and word B, starting with A.
- R10: With select 1000, user mode 10 emits word A once, and user mode 11 emits A and then B once. After that the output is midscale until the test select or the user mode is rewritten, and a rewrite restarts the pattern.
- R11: The user mode field is ignored unless the select is 1000. Changing it under any other select neither alters nor restarts the output sequence.
- R12: With `fmt_twos` high, the MSB of every output word, live data included, is inverted. Midscale then reads 0x0000, positive full scale 0x7FFF and negative full scale 0x8000.
- R13: With `inv_en` high, every output bit is complemented after the format step.
- R14: Reset clears the output to 0x0000, returns the sequence engine to SEQ_FIRST and seeds both generators to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 16 | Live converter sample, offset binary |
| tmode_sel | input | 4 | Test select |
| umode_sel | input | 2 | User playback mode |
| uword_a | input | 16 | User word A |
| uword_b | input | 16 | User word B |
| pn_long_rst | input | 1 | Reseed 23-bit generator |
| pn_short_rst | input | 1 | Reseed 16-bit generator |
| fmt_twos | input | 1 | 1 selects two's complement output |
| inv_en | input | 1 | Complement all output bits |
| out_word | output | 16 | Output word to the serializer |

## Verification
A wrong sequence state shows on the very next valid sample. A pair of words arrives out of phase, or a once-only pattern keeps playing instead of settling at midscale. A corrupted generator register shows on the next sample in its mode as a word that breaks the expected stream. Because both generators step on every valid sample, a missed step stays hidden until that mode is selected, so the bench tracks sample counts since each reseed. A stale mode-change record shows as a pattern that fails to restart on the first sample after a rewrite.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int DW = 16;

    localparam logic [3:0] TM_NORMAL   = 4'd0;
    localparam logic [3:0] TM_MID      = 4'd1;
    localparam logic [3:0] TM_PFS      = 4'd2;
    localparam logic [3:0] TM_NFS      = 4'd3;
    localparam logic [3:0] TM_CHECKER  = 4'd4;
    localparam logic [3:0] TM_PN_LONG  = 4'd5;
    localparam logic [3:0] TM_PN_SHORT = 4'd6;
    localparam logic [3:0] TM_WORD_TGL = 4'd7;
    localparam logic [3:0] TM_USER     = 4'd8;
    localparam logic [3:0] TM_BIT_TGL  = 4'd9;
    localparam logic [3:0] TM_SYNC     = 4'd10;
    localparam logic [3:0] TM_WALK     = 4'd11;
    localparam logic [3:0] TM_MIXED    = 4'd12;

    localparam logic [1:0] UM_REPEAT   = 2'b00;
    localparam logic [1:0] UM_ALT      = 2'b01;
    localparam logic [1:0] UM_ONCE     = 2'b10;
    localparam logic [1:0] UM_ALT_ONCE = 2'b11;

    typedef enum logic [1:0] {
        SEQ_FIRST  = 2'd0,
        SEQ_SECOND = 2'd1,
        SEQ_HOLD   = 2'd2
    } seq_e;

endpackage

// File: rtl/tpg_pn_gen.sv
module tpg_pn_gen #(
    parameter int N     = 23,
    parameter int TAP   = 18,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             reseed,
    output logic [OUT_W-1:0] word
);
    localparam int W = (N > OUT_W) ? N : OUT_W;

    logic [W-1:0] reg_q;
    logic [W-1:0] eff;
    logic         fb;

    always_comb begin
        eff  = reseed ? {W{1'b1}} : reg_q;
        fb   = eff[N-1] ^ eff[TAP-1];
        word = eff[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= {W{1'b1}};
        end else if (adv) begin
            reg_q <= {eff[W-2:0], fb};
        end else if (reseed) begin
            reg_q <= {W{1'b1}};
        end
    end
endmodule

// File: rtl/tpg_seq_fsm.sv
module tpg_seq_fsm
    import tpg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [3:0]       tmode_sel,
    input  logic [1:0]       umode_sel,
    output seq_e             seq_eff,
    output logic [IDX_W-1:0] idx_eff,
    output seq_e             seq_q,
    output logic             mode_chg
);
    logic [3:0]       prev_t;
    logic [1:0]       prev_u;
    logic [IDX_W-1:0] idx_q;
    seq_e             seq_nxt;

    always_comb begin
        mode_chg = (tmode_sel != prev_t) ||
                   ((tmode_sel == TM_USER) && (umode_sel != prev_u));
        seq_eff  = mode_chg ? SEQ_FIRST : seq_q;
        idx_eff  = mode_chg ? '0 : idx_q;
    end

    always_comb begin
        seq_nxt = seq_eff;
        unique case (seq_eff)
            SEQ_FIRST: begin
                if ((tmode_sel == TM_SYNC) ||
                    ((tmode_sel == TM_USER) && (umode_sel == UM_ONCE)))
                    seq_nxt = SEQ_HOLD;
                else
                    seq_nxt = SEQ_SECOND;
            end
            SEQ_SECOND: begin
                if ((tmode_sel == TM_USER) && (umode_sel == UM_ALT_ONCE))
                    seq_nxt = SEQ_HOLD;
                else
                    seq_nxt = SEQ_FIRST;
            end
            SEQ_HOLD: seq_nxt = SEQ_HOLD;
            default:  seq_nxt = SEQ_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= SEQ_FIRST;
            idx_q  <= '0;
            prev_t <= '0;
            prev_u <= '0;
        end else begin
            prev_t <= tmode_sel;
            prev_u <= umode_sel;
            if (smp_vld) begin
                seq_q <= seq_nxt;
                idx_q <= idx_eff + 1'b1;
            end else if (mode_chg) begin
                seq_q <= SEQ_FIRST;
                idx_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tpg_pattern_mux.sv
module tpg_pattern_mux
    import tpg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [3:0]        tmode_sel,
    input  logic [1:0]        umode_sel,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] uword_a,
    input  logic [DATA_W-1:0] uword_b,
    input  logic [DATA_W-1:0] pn_long,
    input  logic [DATA_W-1:0] pn_short,
    input  seq_e              seq_st,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] pattern
);
    localparam logic [DATA_W-1:0] P_MID    = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] P_ONES   = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] P_ZERO   = {DATA_W{1'b0}};
    localparam logic [DATA_W-1:0] P_CHK_A  = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] P_CHK_B  = {(DATA_W/2){2'b01}};
    localparam logic [DATA_W-1:0] P_BIT_A  = {(DATA_W/4){4'h3}};
    localparam logic [DATA_W-1:0] P_BIT_B  = {(DATA_W/4){4'hC}};
    localparam logic [DATA_W-1:0] P_SYNC   = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};
    localparam logic [DATA_W-1:0] P_MIX0   = {(DATA_W/8){8'hA0}};
    localparam logic [DATA_W-1:0] P_MIX1   = {(DATA_W/8){8'h5F}};
    localparam logic [DATA_W-1:0] P_MIX2   = {(DATA_W/8){8'hF5}};
    localparam logic [DATA_W-1:0] P_MIX3   = {(DATA_W/8){8'h0A}};
    localparam logic [DATA_W-1:0] P_LSB    = {{(DATA_W-1){1'b0}}, 1'b1};

    logic first;
    logic [DATA_W-1:0] mix_w;
    logic [DATA_W-1:0] user_w;

    always_comb begin
        first = (seq_st == SEQ_FIRST);

        unique case (idx[1:0])
            2'd0:    mix_w = P_MIX0;
            2'd1:    mix_w = P_MIX1;
            2'd2:    mix_w = P_MIX2;
            default: mix_w = P_MIX3;
        endcase

        unique case (seq_st)
            SEQ_FIRST:  user_w = uword_a;
            SEQ_SECOND: user_w = ((umode_sel == UM_ALT) || (umode_sel == UM_ALT_ONCE))
                                 ? uword_b : uword_a;
            SEQ_HOLD:   user_w = P_MID;
            default:    user_w = P_MID;
        endcase

        case (tmode_sel)
            TM_MID:      pattern = P_MID;
            TM_PFS:      pattern = P_ONES;
            TM_NFS:      pattern = P_ZERO;
            TM_CHECKER:  pattern = first ? P_CHK_A : P_CHK_B;
            TM_PN_LONG:  pattern = pn_long;
            TM_PN_SHORT: pattern = pn_short;
            TM_WORD_TGL: pattern = first ? P_ZERO : P_ONES;
            TM_USER:     pattern = user_w;
            TM_BIT_TGL:  pattern = first ? P_BIT_A : P_BIT_B;
            TM_SYNC:     pattern = first ? P_SYNC : P_MID;
            TM_WALK:     pattern = P_LSB << idx;
            TM_MIXED:    pattern = mix_w;
            default:     pattern = smp_data;
        endcase
    end
endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int DATA_W   = DW,
    parameter int PNL_LEN  = 23,
    parameter int PNL_TAP  = 18,
    parameter int PNS_LEN  = 9,
    parameter int PNS_TAP  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [3:0]        tmode_sel,
    input  logic [1:0]        umode_sel,
    input  logic [DATA_W-1:0] uword_a,
    input  logic [DATA_W-1:0] uword_b,
    input  logic              pn_long_rst,
    input  logic              pn_short_rst,
    input  logic              fmt_twos,
    input  logic              inv_en,
    output logic [DATA_W-1:0] out_word
);
    localparam int IDX_W = $clog2(DATA_W);

    seq_e              seq_eff;
    seq_e              seq_q;
    logic              mode_chg;
    logic [IDX_W-1:0]  idx_eff;
    logic [DATA_W-1:0] pn_long;
    logic [DATA_W-1:0] pn_short;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] shaped;

    tpg_seq_fsm #(.IDX_W(IDX_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .tmode_sel(tmode_sel),
        .umode_sel(umode_sel),
        .seq_eff  (seq_eff),
        .idx_eff  (idx_eff),
        .seq_q    (seq_q),
        .mode_chg (mode_chg)
    );

    tpg_pn_gen #(.N(PNL_LEN), .TAP(PNL_TAP), .OUT_W(DATA_W)) pnl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp_vld),
        .reseed(pn_long_rst),
        .word  (pn_long)
    );

    tpg_pn_gen #(.N(PNS_LEN), .TAP(PNS_TAP), .OUT_W(DATA_W)) pns_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp_vld),
        .reseed(pn_short_rst),
        .word  (pn_short)
    );

    tpg_pattern_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mux_i (
        .tmode_sel(tmode_sel),
        .umode_sel(umode_sel),
        .smp_data (smp_data),
        .uword_a  (uword_a),
        .uword_b  (uword_b),
        .pn_long  (pn_long),
        .pn_short (pn_short),
        .seq_st   (seq_eff),
        .idx      (idx_eff),
        .pattern  (pattern)
    );

    always_comb begin
        shaped = pattern ^ {fmt_twos, {(DATA_W-1){1'b0}}};
        shaped = shaped ^ {DATA_W{inv_en}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
        end else if (smp_vld) begin
            out_word <= shaped;
        end
    end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
    import tpg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        smp_vld,
    input logic [15:0] smp_data,
    input logic [3:0]  tmode_sel,
    input logic        pn_long_rst,
    input logic        fmt_twos,
    input logic        inv_en,
    input logic [15:0] out_word,
    input seq_e        seq_q,
    input logic        mode_chg
);
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(out_word));

    a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && tmode_sel == TM_NORMAL) |=>
        out_word == ($past(smp_data) ^ {$past(fmt_twos), 15'b0} ^ {16{$past(inv_en)}}));

    a_r2_pos_full: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && tmode_sel == TM_PFS) |=>
        out_word == (16'hFFFF ^ {$past(fmt_twos), 15'b0} ^ {16{$past(inv_en)}}));

    a_r8_long_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pn_long_rst && tmode_sel == TM_PN_LONG) |=>
        out_word == (16'hFFFF ^ {$past(fmt_twos), 15'b0} ^ {16{$past(inv_en)}}));

    a_r10_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_HOLD && !mode_chg) |=> seq_q == SEQ_HOLD);
endmodule

bind tpg_top tpg_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .tmode_sel  (tmode_sel),
    .pn_long_rst(pn_long_rst),
    .fmt_twos   (fmt_twos),
    .inv_en     (inv_en),
    .out_word   (out_word),
    .seq_q      (seq_q),
    .mode_chg   (mode_chg)
);

// File: tb/tpg_top_tb_top.sv
`timescale 1ns/1ps
module tpg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_data = '0;
    logic [3:0]  tmode_sel = '0;
    logic [1:0]  umode_sel = '0;
    logic [15:0] uword_a = 16'h1357;
    logic [15:0] uword_b = 16'h2468;
    logic        pn_long_rst = 1'b0;
    logic        pn_short_rst = 1'b0;
    logic        fmt_twos = 1'b0;
    logic        inv_en = 1'b0;
    logic [15:0] out_word;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tpg_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_data    (smp_data),
        .tmode_sel   (tmode_sel),
        .umode_sel   (umode_sel),
        .uword_a     (uword_a),
        .uword_b     (uword_b),
        .pn_long_rst (pn_long_rst),
        .pn_short_rst(pn_short_rst),
        .fmt_twos    (fmt_twos),
        .inv_en      (inv_en),
        .out_word    (out_word)
    );

    function automatic logic [22:0] long_nx(input logic [22:0] r);
        return {r[21:0], r[22] ^ r[17]};
    endfunction

    function automatic logic [15:0] short_nx(input logic [15:0] r);
        return {r[14:0], r[8] ^ r[4]};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one valid sample; returns the word visible after the edge
    task automatic sample(output logic [15:0] got);
        smp_vld = 1'b1;
        @(posedge clk); #1;
        got = out_word;
        smp_vld = 1'b0;
        pn_long_rst = 1'b0;
        pn_short_rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic go_mode(input logic [3:0] t, input logic [1:0] u);
        tmode_sel = 4'd0;
        idle(1);
        tmode_sel = t;
        umode_sel = u;
    endtask

    task automatic expect_seq(input string req, input logic [15:0] w0, input logic [15:0] w1,
                              input logic [15:0] w2);
        logic [15:0] g;
        sample(g); check(req, g, w0);
        sample(g); check(req, g, w1);
        sample(g); check(req, g, w2);
    endtask

    task automatic t_reset;
        check("R14 reset output", out_word, 16'h0000);
    endtask

    task automatic t_normal;
        logic [15:0] g;
        go_mode(4'd0, 2'd0);
        smp_data = 16'h1234; sample(g); check("R1 pass normal", g, 16'h1234);
        tmode_sel = 4'd13; smp_data = 16'hBEEF; sample(g); check("R1 pass reserved", g, 16'hBEEF);
        smp_data = 16'h0F0F; idle(2); check("R1 hold idle", out_word, 16'hBEEF);
    endtask

    task automatic t_const;
        logic [15:0] g;
        go_mode(4'd1, 2'd0); sample(g); check("R2 midscale", g, 16'h8000);
        go_mode(4'd2, 2'd0); sample(g); check("R2 pos full", g, 16'hFFFF);
        go_mode(4'd3, 2'd0); sample(g); check("R2 neg full", g, 16'h0000);
    endtask

    task automatic t_toggle;
        logic [15:0] g;
        go_mode(4'd4, 2'd0);
        expect_seq("R3 checker", 16'hAAAA, 16'h5555, 16'hAAAA);
        idle(3);
        sample(g); check("R3 gap no advance", g, 16'h5555);
        go_mode(4'd7, 2'd0);
        expect_seq("R3 word toggle", 16'h0000, 16'hFFFF, 16'h0000);
        go_mode(4'd9, 2'd0);
        expect_seq("R3 bit toggle", 16'h3333, 16'hCCCC, 16'h3333);
    endtask

    task automatic t_mixed_walk;
        logic [15:0] g;
        logic [15:0] mix [4];
        mix[0] = 16'hA0A0; mix[1] = 16'h5F5F; mix[2] = 16'hF5F5; mix[3] = 16'h0A0A;
        go_mode(4'd12, 2'd0);
        for (int i = 0; i < 5; i++) begin
            sample(g); check("R4 mixed", g, mix[i % 4]);
        end
        go_mode(4'd11, 2'd0);
        for (int i = 0; i < 17; i++) begin
            sample(g); check("R4 walk", g, 16'h0001 << (i % 16));
        end
    endtask

    task automatic t_sync;
        go_mode(4'd10, 2'd0);
        expect_seq("R5 sync", 16'hFF00, 16'h8000, 16'h8000);
    endtask

    task automatic t_pn_long;
        logic [15:0] g;
        logic [22:0] m;
        go_mode(4'd5, 2'd0);
        m = '1;
        pn_long_rst = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sample(g); check("R6 long pn", g, m[15:0]);
            m = long_nx(m);
        end
    endtask

    task automatic t_pn_short;
        logic [15:0] g;
        logic [15:0] m;
        go_mode(4'd6, 2'd0);
        m = '1;
        pn_short_rst = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sample(g); check("R7 short pn", g, m);
            m = short_nx(m);
        end
    endtask

    task automatic t_pn_indep;
        logic [15:0] g;
        logic [15:0] m;
        go_mode(4'd6, 2'd0);
        m = '1;
        pn_short_rst = 1'b1;
        sample(g); check("R8 short seed", g, m);
        m = short_nx(m);
        go_mode(4'd5, 2'd0);
        pn_long_rst = 1'b1;
        sample(g); check("R8 long seed", g, 16'hFFFF);
        m = short_nx(m);
        go_mode(4'd6, 2'd0);
        sample(g); check("R8 short untouched", g, m);
    endtask

    task automatic t_user_rep;
        go_mode(4'd8, 2'b00);
        expect_seq("R9 repeat", 16'h1357, 16'h1357, 16'h1357);
        go_mode(4'd8, 2'b01);
        expect_seq("R9 alternate", 16'h1357, 16'h2468, 16'h1357);
    endtask

    task automatic t_user_once;
        logic [15:0] g;
        go_mode(4'd8, 2'b10);
        expect_seq("R10 once", 16'h1357, 16'h8000, 16'h8000);
        go_mode(4'd8, 2'b11);
        expect_seq("R10 alt once", 16'h1357, 16'h2468, 16'h8000);
        sample(g); check("R10 alt once hold", g, 16'h8000);
        umode_sel = 2'b10;
        sample(g); check("R10 rewrite restarts", g, 16'h1357);
    endtask

    task automatic t_umode_ignored;
        logic [15:0] g;
        go_mode(4'd4, 2'b00);
        sample(g); check("R11 checker start", g, 16'hAAAA);
        umode_sel = 2'b11;
        sample(g); check("R11 umode ignored", g, 16'h5555);
        umode_sel = 2'b01;
        sample(g); check("R11 umode ignored", g, 16'hAAAA);
    endtask

    task automatic t_format;
        logic [15:0] g;
        fmt_twos = 1'b1;
        go_mode(4'd1, 2'd0); sample(g); check("R12 twos mid", g, 16'h0000);
        go_mode(4'd2, 2'd0); sample(g); check("R12 twos pfs", g, 16'h7FFF);
        go_mode(4'd3, 2'd0); sample(g); check("R12 twos nfs", g, 16'h8000);
        go_mode(4'd0, 2'd0); smp_data = 16'h1234; sample(g); check("R12 twos data", g, 16'h9234);
        fmt_twos = 1'b0;
    endtask

    task automatic t_invert;
        logic [15:0] g;
        inv_en = 1'b1;
        go_mode(4'd2, 2'd0); sample(g); check("R13 inv pfs", g, 16'h0000);
        fmt_twos = 1'b1;
        go_mode(4'd1, 2'd0); sample(g); check("R13 inv after fmt", g, 16'hFFFF);
        go_mode(4'd4, 2'd0); sample(g); check("R13 inv checker", g, 16'hD555);
        inv_en = 1'b0; fmt_twos = 1'b0;
    endtask

    task automatic t_reset_seeds;
        logic [15:0] g;
        tmode_sel = 4'd4;
        sample(g);
        rst_n = 1'b0; idle(2);
        check("R14 reset clears", out_word, 16'h0000);
        rst_n = 1'b1; idle(1);
        sample(g); check("R14 seq first", g, 16'hAAAA);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        tmode_sel = 4'd5; idle(1);
        sample(g); check("R14 long seeded", g, 16'hFFFF);
        go_mode(4'd6, 2'd0);
        sample(g); check("R14 short after reset", g, short_nx(16'hFFFF));
    endtask

    initial begin
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_normal;
        t_const;
        t_toggle;
        t_mixed_walk;
        t_sync;
        t_pn_long;
        t_pn_short;
        t_pn_indep;
        t_user_rep;
        t_user_once;
        t_umode_ignored;
        t_format;
        t_invert;
        t_reset_seeds;
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule